// File: doc/BRIEF.md
# DRAM Refresh and Address-Multiplex Controller

This block sits between a simple request/acknowledge host port and one external memory region holding a 16-bit-wide DRAM or pseudo-static RAM. For a host access it places the row half of the word address on the memory address pins and drops RAS. One clock later it places the column half and drops the byte-lane strobes. It then holds the strobes through a programmable number of wait states and acknowledges the host. The data lines connect the host and the memory directly and do not pass through the block.

An 8-bit interval counter runs from a prescaled clock and compares against a programmable value. On a match in a refresh mode it posts a refresh request. In DRAM mode the request is served as a CAS-before-RAS cycle. In pseudo-static mode it is served as a pulse on a dedicated refresh strobe. In timer mode the match raises a one-cycle interrupt and no refresh is ever run. A self-refresh control holds the memory in its self-refresh state until software releases it.

The sequencer states are ST_IDLE, ST_ROW, ST_COL, ST_ACK, ST_CBR_CAS, ST_CBR_RAS, ST_PS_RFSH, ST_SELF and ST_RPRE.

Its transitions are:
- IDLE→CBR_CAS when self refresh is requested in DRAM mode.
- IDLE→SELF when self refresh is requested in pseudo-static mode.
- IDLE→CBR_CAS or IDLE→PS_RFSH when a refresh is pending.
- IDLE→ROW when the host requests an access. Requests are taken in that order of priority.
- ROW→COL.
- COL→ACK after the last wait state.
- ACK→IDLE.
- CBR_CAS→SELF while self refresh is requested, otherwise CBR_CAS→CBR_RAS.
- CBR_RAS→RPRE and PS_RFSH→RPRE after the last wait state.
- SELF→RPRE when self refresh is released.
- RPRE→IDLE.

Top module: `dram_rfsh_ctrl`

## Requirements
- R1: While rst_n is low, all memory strobes are high, host_ack is low and timer_irq is low.
- R2: A host access drives RAS low with the row address for exactly one cycle before any CAS or WE strobe falls. RAS then stays low for the whole column phase.
- R3: With cfg_col9=0 the column is host_waddr[7:0] and the row is host_waddr[18:8]. With cfg_col9=1 the column is host_waddr[8:0] and the row is host_waddr[19:9]. Columns are zero-extended on mem_addr.
- R4: With cfg_two_we=0, cas_hi_n = !host_be[1] and cas_lo_n = !host_be[0] in the column phase. Both WE pins equal !host_we. oe_n equals host_we.
- R5: With cfg_two_we=1, both CAS pins are low in the column phase. we_hi_n = !(host_we & host_be[1]) and we_lo_n = !(host_we & host_be[0]). oe_n equals host_we.
- R6: The column phase lasts cfg_wait+1 cycles. In the next cycle host_ack is high for one cycle with all strobes high.
- R7: In DRAM mode (cfg_mode=0) a refresh drives both CAS low with RAS, WE and OE high for one cycle. RAS then falls, and CAS and RAS stay low for cfg_wait+1 cycles before all strobes return high. No acknowledge is given.
- R8: The interval counter matches every (cfg_cmp+1)·2^cfg_psc clock cycles.
- R9: A refresh that comes due during a host access runs right after that access. A host request raised during a refresh is taken only after the refresh and its recovery cycle.
- R10: With cfg_self=1 in DRAM mode, CAS falls and then RAS, and both stay low with no host access served. Clearing cfg_self raises all strobes in the next cycle.
- R11: In pseudo-static mode (cfg_mode=1) a refresh drives psr_rfsh_n low for cfg_wait+1 cycles while RAS and CAS stay high.
- R12: In timer mode (cfg_mode[1]=1) each match gives a one-cycle timer_irq pulse, and RAS and psr_rfsh_n stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 DRAM refresh, 1 pseudo-static refresh, 2/3 interval timer |
| cfg_two_we | input | 1 | 1 selects byte lanes on WE pins, 0 on CAS pins |
| cfg_col9 | input | 1 | 1 selects 9-bit column, 0 selects 8-bit |
| cfg_wait | input | 3 | Wait states added to column and refresh phases |
| cfg_cmp | input | 8 | Interval compare value |
| cfg_psc | input | 2 | Prescaler select, divide by 2^cfg_psc |
| cfg_self | input | 1 | Self-refresh request |
| host_req | input | 1 | Host access request, held until acknowledge |
| host_we | input | 1 | 1 write, 0 read |
| host_be | input | 2 | Byte enables, bit 1 upper lane |
| host_waddr | input | 20 | Host word address |
| host_ack | output | 1 | One-cycle access acknowledge |
| mem_addr | output | 11 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe |
| cas_hi_n | output | 1 | Upper column strobe |
| cas_lo_n | output | 1 | Lower column strobe |
| we_hi_n | output | 1 | Upper write strobe |
| we_lo_n | output | 1 | Lower write strobe |
| oe_n | output | 1 | Output enable |
| psr_rfsh_n | output | 1 | Pseudo-static refresh strobe |
| timer_irq | output | 1 | Interval match pulse in timer mode |

## Verification
The hardest case to reach from the ports is a collision between a refresh and a host access. The bench sets the interval to twelve cycles and the wait count to seven. It watches for the CAS-only cycle that opens a refresh and raises a host request in that same cycle. This makes the request wait through the whole refresh. The access that follows runs long enough for the next interval to fall inside it, so the deferred refresh must start straight after the acknowledge. The bench counts the cycles at both points exactly.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        MODE_DRAM  = 2'd0,
        MODE_PSRAM = 2'd1,
        MODE_TIMER = 2'd2
    } rf_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_ACK,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_PS_RFSH,
        ST_SELF,
        ST_RPRE
    } seq_state_e;

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_sel,
    input  logic [CNT_W-1:0] cmp,
    output logic             match
);
    localparam int PDIV_W = (1 << PSC_W) - 1;

    logic [PDIV_W-1:0] pre_q;
    logic [PDIV_W-1:0] pre_mask;
    logic [CNT_W-1:0]  cnt_q;
    logic              tick;

    always_comb begin
        pre_mask = '0;
        for (int i = 0; i < PDIV_W; i++) begin
            if (i < int'(psc_sel)) pre_mask[i] = 1'b1;
        end
    end

    assign tick  = &(pre_q | ~pre_mask);
    assign match = tick && (cnt_q == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (match)     cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
    parameter int  MA_W = 11,
    localparam int WA_W = MA_W + 9
) (
    input  logic [WA_W-1:0] waddr,
    input  logic            col9,
    input  logic            col_phase,
    output logic [MA_W-1:0] mem_addr
);
    logic [MA_W-1:0] row_a;
    logic [MA_W-1:0] col_a;

    always_comb begin
        row_a = col9 ? waddr[9 +: MA_W] : waddr[8 +: MA_W];
        col_a = col9 ? {{(MA_W-9){1'b0}}, waddr[8:0]}
                     : {{(MA_W-8){1'b0}}, waddr[7:0]};
        mem_addr = col_phase ? col_a : row_a;
    end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              two_we,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic              self_on,
    input  logic              rfsh_pend,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_be,
    output logic              rfsh_start,
    output logic              col_phase,
    output logic              host_ack,
    output logic              ras_n,
    output logic              cas_hi_n,
    output logic              cas_lo_n,
    output logic              we_hi_n,
    output logic              we_lo_n,
    output logic              oe_n,
    output logic              psr_rfsh_n
);
    seq_state_e        st_q, st_d;
    logic [WAIT_W-1:0] wcnt_q;
    logic              is_dram;
    logic              counting;

    assign is_dram  = (mode == MODE_DRAM);
    assign counting = (st_q == ST_COL) || (st_q == ST_CBR_RAS) || (st_q == ST_PS_RFSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            wcnt_q <= counting ? wcnt_q - 1'b1 : wait_n;
        end
    end

    always_comb begin
        st_d       = st_q;
        rfsh_start = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (self_on) begin
                    st_d = is_dram ? ST_CBR_CAS : ST_SELF;
                end else if (rfsh_pend) begin
                    st_d       = is_dram ? ST_CBR_CAS : ST_PS_RFSH;
                    rfsh_start = 1'b1;
                end else if (host_req) begin
                    st_d = ST_ROW;
                end
            end
            ST_ROW:     st_d = ST_COL;
            ST_COL:     if (wcnt_q == '0) st_d = ST_ACK;
            ST_ACK:     st_d = ST_IDLE;
            ST_CBR_CAS: st_d = self_on ? ST_SELF : ST_CBR_RAS;
            ST_CBR_RAS,
            ST_PS_RFSH: if (wcnt_q == '0) st_d = ST_RPRE;
            ST_SELF:    if (!self_on) st_d = ST_RPRE;
            ST_RPRE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        col_phase  = 1'b0;
        host_ack   = 1'b0;
        ras_n      = 1'b1;
        cas_hi_n   = 1'b1;
        cas_lo_n   = 1'b1;
        we_hi_n    = 1'b1;
        we_lo_n    = 1'b1;
        oe_n       = 1'b1;
        psr_rfsh_n = 1'b1;
        unique case (st_q)
            ST_ROW: ras_n = 1'b0;
            ST_COL: begin
                col_phase = 1'b1;
                ras_n     = 1'b0;
                oe_n      = host_we;
                if (two_we) begin
                    cas_hi_n = 1'b0;
                    cas_lo_n = 1'b0;
                    we_hi_n  = ~(host_we & host_be[1]);
                    we_lo_n  = ~(host_we & host_be[0]);
                end else begin
                    cas_hi_n = ~host_be[1];
                    cas_lo_n = ~host_be[0];
                    we_hi_n  = ~host_we;
                    we_lo_n  = ~host_we;
                end
            end
            ST_ACK: host_ack = 1'b1;
            ST_CBR_CAS: begin
                cas_hi_n = 1'b0;
                cas_lo_n = 1'b0;
            end
            ST_CBR_RAS: begin
                ras_n    = 1'b0;
                cas_hi_n = 1'b0;
                cas_lo_n = 1'b0;
            end
            ST_PS_RFSH: psr_rfsh_n = 1'b0;
            ST_SELF: begin
                if (is_dram) begin
                    ras_n    = 1'b0;
                    cas_hi_n = 1'b0;
                    cas_lo_n = 1'b0;
                end else begin
                    psr_rfsh_n = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_rfsh_ctrl.sv
module dram_rfsh_ctrl
    import dram_rfsh_pkg::*;
#(
    parameter int  MA_W   = 11,
    parameter int  WAIT_W = 3,
    parameter int  CNT_W  = 8,
    parameter int  PSC_W  = 2,
    localparam int WA_W   = MA_W + 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_two_we,
    input  logic              cfg_col9,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [CNT_W-1:0]  cfg_cmp,
    input  logic [PSC_W-1:0]  cfg_psc,
    input  logic              cfg_self,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_be,
    input  logic [WA_W-1:0]   host_waddr,
    output logic              host_ack,
    output logic [MA_W-1:0]   mem_addr,
    output logic              ras_n,
    output logic              cas_hi_n,
    output logic              cas_lo_n,
    output logic              we_hi_n,
    output logic              we_lo_n,
    output logic              oe_n,
    output logic              psr_rfsh_n,
    output logic              timer_irq
);
    logic is_timer;
    logic self_on;
    logic match;
    logic rfsh_pend_q;
    logic rfsh_start;
    logic col_phase;

    assign is_timer = cfg_mode[1];
    assign self_on  = cfg_self && !is_timer;

    rfsh_tick_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc_sel (cfg_psc),
        .cmp     (cfg_cmp),
        .match   (match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rfsh_pend_q <= 1'b0;
            timer_irq   <= 1'b0;
        end else begin
            timer_irq <= match && is_timer;
            if (is_timer || rfsh_start)     rfsh_pend_q <= 1'b0;
            else if (match && !self_on)     rfsh_pend_q <= 1'b1;
        end
    end

    dram_seq_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cfg_mode),
        .two_we     (cfg_two_we),
        .wait_n     (cfg_wait),
        .self_on    (self_on),
        .rfsh_pend  (rfsh_pend_q),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_be    (host_be),
        .rfsh_start (rfsh_start),
        .col_phase  (col_phase),
        .host_ack   (host_ack),
        .ras_n      (ras_n),
        .cas_hi_n   (cas_hi_n),
        .cas_lo_n   (cas_lo_n),
        .we_hi_n    (we_hi_n),
        .we_lo_n    (we_lo_n),
        .oe_n       (oe_n),
        .psr_rfsh_n (psr_rfsh_n)
    );

    dram_addr_mux #(.MA_W(MA_W)) u_mux (
        .waddr     (host_waddr),
        .col9      (cfg_col9),
        .col_phase (col_phase),
        .mem_addr  (mem_addr)
    );

endmodule

// File: rtl/dram_rfsh_ctrl_chk.sv
module dram_rfsh_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       host_ack,
    input logic       ras_n,
    input logic       cas_hi_n,
    input logic       cas_lo_n,
    input logic       we_hi_n,
    input logic       we_lo_n,
    input logic       oe_n,
    input logic       psr_rfsh_n,
    input logic       timer_irq
);
    // R2: the row-only cycle is followed by RAS still low for the column phase
    a_r2_ras_spans_column: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_hi_n && cas_lo_n) |=> !ras_n);

    // R6: acknowledge cycle has every strobe released
    a_r6_ack_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (ras_n && cas_hi_n && cas_lo_n && we_hi_n && we_lo_n && oe_n));

    // R6: acknowledge lasts one cycle
    a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R7: CAS-only cycle leads to RAS falling with CAS held
    a_r7_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_hi_n && !cas_lo_n && ras_n) |=> (!ras_n && !cas_hi_n && !cas_lo_n));

    // R7: no write or read enable during the CAS-only cycle
    a_r7_cbr_no_we_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_lo_n && ras_n) |-> (we_hi_n && we_lo_n && oe_n));

    // R11: pseudo-static refresh strobe never overlaps DRAM strobes or an acknowledge
    a_r11_psram_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !psr_rfsh_n |-> (ras_n && cas_hi_n && cas_lo_n && !host_ack));

    // R12: the interrupt only follows a cycle spent in timer mode
    a_r12_irq_in_timer: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> $past(cfg_mode[1]));

endmodule

bind dram_rfsh_ctrl dram_rfsh_ctrl_chk u_chk (.*);

// File: tb/dram_rfsh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd2;
    logic        cfg_two_we = 1'b0, cfg_col9 = 1'b0, cfg_self = 1'b0;
    logic [2:0]  cfg_wait = 3'd0;
    logic [7:0]  cfg_cmp = 8'd200;
    logic [1:0]  cfg_psc = 2'd0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_be = 2'b11;
    logic [19:0] host_waddr = '0;
    logic        host_ack, ras_n, cas_hi_n, cas_lo_n, we_hi_n, we_lo_n, oe_n, psr_rfsh_n, timer_irq;
    logic [10:0] mem_addr;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    dram_rfsh_ctrl dut_i (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic set_cfg(logic [1:0] m, logic twe, logic c9, logic [2:0] w, logic [7:0] c, logic [1:0] p);
        @(negedge clk);
        cfg_mode = m; cfg_two_we = twe; cfg_col9 = c9; cfg_wait = w; cfg_cmp = c; cfg_psc = p;
    endtask

    function automatic logic [5:0] strobes();
        return {ras_n, cas_hi_n, cas_lo_n, we_hi_n, we_lo_n, oe_n};
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "strobes in reset", {26'd0, strobes()}, 32'h3F);
        chk("R1", "psram strobe in reset", psr_rfsh_n, 1);
        chk("R1", "ack/irq in reset", {host_ack, timer_irq}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_access(string lane, logic twe, logic c9, logic we, logic [1:0] be,
                            logic [19:0] wa, logic [2:0] w);
        logic [10:0] e_row, e_col;
        set_cfg(2'd2, twe, c9, w, 8'd200, 2'd0);
        e_col = c9 ? {2'b0, wa[8:0]} : {3'b0, wa[7:0]};
        e_row = c9 ? wa[19:9] : wa[18:8];
        host_we = we; host_be = be; host_waddr = wa; host_req = 1'b1;
        @(negedge clk);
        chk("R2", "row phase ras/cas", {ras_n, cas_hi_n, cas_lo_n}, 3'b011);
        chk("R3", "row address", mem_addr, e_row);
        for (int k = 0; k <= int'(w); k++) begin
            @(negedge clk);
            chk("R2", "ras low in column phase", ras_n, 0);
            chk("R3", "column address", mem_addr, e_col);
            chk(lane, "cas hi/lo", {cas_hi_n, cas_lo_n},
                twe ? 2'b00 : {~be[1], ~be[0]});
            chk(lane, "we hi/lo", {we_hi_n, we_lo_n},
                twe ? {~(we & be[1]), ~(we & be[0])} : {~we, ~we});
            chk(lane, "oe", oe_n, we);
            chk("R6", "no ack during wait", host_ack, 0);
        end
        @(negedge clk);
        chk("R6", "ack after last wait", host_ack, 1);
        chk("R6", "strobes high at ack", {26'd0, strobes()}, 32'h3F);
        host_req = 1'b0;
        @(negedge clk);
        chk("R6", "ack single cycle", host_ack, 0);
    endtask

    task automatic t_interval(logic [7:0] c, logic [1:0] p);
        bit found = 0, quiet = 1;
        int n = 0;
        logic second = 1'b0;
        set_cfg(2'd2, 0, 0, 0, c, p);
        for (int i = 0; i < 4000 && !found; i++) begin
            @(negedge clk);
            if (timer_irq) found = 1;
        end
        chk("R12", "first irq seen", found, 1);
        do begin
            @(negedge clk);
            n++;
            if (n == 1) second = timer_irq;
            if (!ras_n || !psr_rfsh_n) quiet = 0;
        end while (!timer_irq && n < 5000);
        chk("R8", "match period", n, (int'(c) + 1) << p);
        chk("R12", "irq one cycle", second, 0);
        chk("R12", "no refresh strobes in timer mode", quiet, 1);
    endtask

    task automatic wait_cbr(output bit found, input int lim);
        found = 0;
        for (int i = 0; i < lim && !found; i++) begin
            @(negedge clk);
            if (!cas_lo_n && ras_n) found = 1;
        end
    endtask

    task automatic t_cbr(logic [2:0] w);
        bit found;
        set_cfg(2'd0, 0, 0, w, 8'd15, 2'd0);
        wait_cbr(found, 100);
        chk("R7", "cas-before-ras start seen", found, 1);
        chk("R7", "cas-only cycle", {26'd0, strobes()}, 32'b100111);
        for (int k = 0; k <= int'(w); k++) begin
            @(negedge clk);
            chk("R7", "ras+cas low", {ras_n, cas_hi_n, cas_lo_n}, 0);
            chk("R7", "no ack in refresh", host_ack, 0);
        end
        @(negedge clk);
        chk("R7", "strobes released", {26'd0, strobes()}, 32'h3F);
    endtask

    task automatic t_pending();
        bit found, acked = 0;
        int n = 0, n2 = 0;
        set_cfg(2'd0, 0, 0, 3'd7, 8'd11, 2'd0);
        wait_cbr(found, 100);
        chk("R9", "refresh start seen", found, 1);
        host_we = 1'b0; host_be = 2'b11; host_waddr = 20'h1234; host_req = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (host_ack) acked = 1;
        end while (!(!ras_n && cas_hi_n && cas_lo_n) && n < 40);
        chk("R9", "host waits through refresh (cycles)", n, 11);
        chk("R9", "no ack during refresh", acked, 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 40);
        chk("R9", "access acknowledged", host_ack, 1);
        host_req = 1'b0;
        do begin
            @(negedge clk);
            n2++;
        end while (!(!cas_lo_n && ras_n) && n2 < 10);
        chk("R9", "deferred refresh after ack (cycles)", n2, 2);
    endtask

    task automatic t_self();
        bit found, low = 1, acked = 0;
        int n = 0;
        set_cfg(2'd0, 0, 0, 3'd1, 8'd255, 2'd3);
        cfg_self = 1'b1;
        wait_cbr(found, 40);
        chk("R10", "self refresh entry via cas first", found, 1);
        host_waddr = 20'h00ABC; host_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ras_n || cas_hi_n || cas_lo_n) low = 0;
            if (host_ack) acked = 1;
        end
        chk("R10", "ras/cas held low", low, 1);
        chk("R10", "host not served", acked, 0);
        cfg_self = 1'b0;
        @(negedge clk);
        chk("R10", "strobes released after exit", {26'd0, strobes()}, 32'h3F);
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack && n < 60);
        chk("R10", "host served after exit", host_ack, 1);
        host_req = 1'b0;
    endtask

    task automatic t_psram();
        bit found = 0, clean = 1;
        int n = 1;
        set_cfg(2'd1, 0, 0, 3'd2, 8'd15, 2'd0);
        for (int i = 0; i < 100 && !found; i++) begin
            @(negedge clk);
            if (!psr_rfsh_n) found = 1;
        end
        chk("R11", "psram refresh seen", found, 1);
        forever begin
            if (!ras_n || !cas_hi_n || !cas_lo_n) clean = 0;
            @(negedge clk);
            if (psr_rfsh_n || n > 20) break;
            n++;
        end
        chk("R11", "refresh strobe width", n, 3);
        chk("R11", "dram strobes high", clean, 1);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        t_reset();
        t_access("R4", 0, 0, 0, 2'b11, 20'hA5C3D, 3'd0);
        t_access("R4", 0, 1, 1, 2'b10, 20'h5F1E7, 3'd2);
        t_access("R4", 0, 0, 1, 2'b01, 20'hFFFFF, 3'd7);
        t_access("R5", 1, 1, 1, 2'b01, 20'h3C0F0, 3'd1);
        t_access("R5", 1, 0, 0, 2'b11, 20'h80101, 3'd3);
        t_interval(8'd9, 2'd0);
        t_interval(8'd4, 2'd2);
        t_interval(8'd0, 2'd3);
        t_cbr(3'd0);
        t_cbr(3'd3);
        t_pending();
        t_self();
        t_psram();
        summary();
    end

endmodule